// File: doc/BRIEF.md
# Flash Query and Identifier Responder

This block forms the read data that a bank of identical parallel flash devices returns while it is in query mode or in identifier mode. Outside logic decodes the commands and owns the array. While one of those two modes is active, it hands each bus read to this block as a request: the bus byte offset, the mode and the read size. The block answers with the word that the whole bank would drive. The static configuration arrives on plain pins:

- the bank width, the device width and the device's widest supported width, each given as a log2 byte code;
- the manufacturer and device identifier codes;
- the sector size in bytes and the total sector count.

The block handles three things a real bank does. When a device runs narrower than its widest mode, the offset is scaled down to the device's own query address. A wide part in byte mode answers with its table byte in every byte position, with no zero padding. Every device in the bank answers at once, so the response of one device appears in every device lane. A read wider than the bank is built from consecutive bank-wide slices. The query table is held inside the block. Its geometry entries are derived from the configuration.

Requests and responses use valid/ready. `req_ready` is high whenever the output register is empty or is being emptied in the same cycle. A response held with `rsp_ready` low blocks new requests and keeps its value. Width codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = illegal. `req_id_mode` is 1 for identifier mode and 0 for query mode.

Top module: `flash_query_responder`

## Requirements
- R1: A request accepted while `req_valid` and `req_ready` are both high at a clock edge gives `rsp_valid` high after that edge. `req_ready` equals (not `rsp_valid`) or `rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_cfg_error` hold their values.
- R2: After reset, `rsp_valid` is low, `rsp_data` is zero and `req_ready` is high.
- R3: The table index is the request offset shifted right by bank code + max code - device code.
- R4: Query entries hold these fixed values: 0x10..0x12 = 0x51,0x52,0x59 ("QRY"); 0x13 = 0x01; 0x15 = 0x31; 0x1B = 0x45; 0x1C = 0x55; 0x1F = 0x07; 0x20 = 0x07; 0x21 = 0x0A; 0x23..0x25 = 0x04; 0x28 = 0x02; 0x2C = 0x01 (one uniform erase region); 0x31..0x35 = "PRI10"; 0x3F = 0x01. All other entries below 0x52 are zero.
- R5: A query index of 0x52 or above returns a zero byte.
- R6: Entry 0x27 is log2 of the per-device size, where the size is sector bytes x (sector count / devices in bank). Entry 0x2A is 8 for a 1-byte bank and 11 otherwise. Entries 0x2D/0x2E hold the per-device block count minus one, low byte first. Entries 0x2F/0x30 hold the sector size divided by 256, low byte first.
- R7: When the device code is below the max code (byte mode), the table byte appears in every byte lane of the bank slice.
- R8: When the device is narrower than the bank, the device-width response is copied into every device lane. A device response in query mode at full width is the table byte, zero-extended to the device width.
- R9: In identifier mode only the low 8 bits of the scaled index are decoded: 0 returns the manufacturer code, 1 returns the device code, and anything else returns 0. The result is truncated to the device width and then replicated across the lanes.
- R10: When the read size exceeds the bank width, slice k is queried at offset + k x bank bytes and placed at byte k x bank bytes. Bytes above the larger of the read size and the bank width are zero.
- R11: A configuration error occurs when any code is 3, when device > max, when device > bank, or when device differs from max with a device code other than 0. It gives `rsp_cfg_error` = 1 with `rsp_data` = 0. `rsp_cfg_error` is high only together with `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_offset | input | ADDR_W | Bus byte offset of the read |
| req_id_mode | input | 1 | 1 = identifier mode, 0 = query mode |
| req_size_lg | input | 2 | log2 of read size in bytes |
| cfg_bank_lg | input | 2 | log2 of bank width in bytes |
| cfg_dev_lg | input | 2 | log2 of device width as used |
| cfg_max_lg | input | 2 | log2 of device's widest mode |
| cfg_mfr_code | input | 16 | Manufacturer identifier |
| cfg_dev_code | input | 16 | Device identifier |
| cfg_sector_bytes | input | SEC_W | Sector size in bytes (power of two) |
| cfg_block_count | input | BLK_W | Sectors in the whole bank |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | 32 | Response word |
| rsp_cfg_error | output | 1 | Unsupported width configuration |

## Verification
Four geometries are tried: 4/1/2 (byte mode on a 16-bit part in a 32-bit bank), 2/2/2, 4/2/2 and 1/1/1. A given table byte then shows up as a repeated byte, a zero-extended halfword, or a halfword-pair pattern. This separates index scaling from lane replication. Reads of each size are also made on narrow banks, so that slice assembly at offset + k x bank is told apart from a single widened query. Identifier reads at indices 0, 1, 2 and 0x100 separate low-byte decoding from full decoding. Illegal codes and combinations are tried, and a stalled output checks the hold and back-pressure rules.

// File: rtl/fqr_pkg.sv
package fqr_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int TABLE_LEN  = 'h52;
  localparam int IDX_W      = 7;

  typedef logic [1:0] wcode_t;

  typedef struct packed {
    logic [7:0]  dev_size_lg;
    logic [7:0]  wbuf_lg;
    logic [15:0] blocks_m1;
    logic [15:0] sector_units;
  } geom_t;

  function automatic logic [7:0] trailing_zeros(input logic [31:0] v);
    logic [7:0] n;
    logic       hit;
    n   = 8'd0;
    hit = 1'b0;
    for (int i = 0; i < 32; i++) begin
      if (!hit && !v[i]) n = n + 8'd1;
      else hit = 1'b1;
    end
    return n;
  endfunction

  function automatic logic [31:0] width_mask(input wcode_t c);
    case (c)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [1:0] lane_mask(input wcode_t c);
    case (c)
      2'd0:    return 2'b00;
      2'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction
endpackage

// File: rtl/fqr_geometry.sv
module fqr_geometry
  import fqr_pkg::*;
#(
  parameter int SEC_W = 24,
  parameter int BLK_W = 16
) (
  input  wcode_t             bank_lg,
  input  wcode_t             dev_lg,
  input  wcode_t             max_lg,
  input  wcode_t             size_lg,
  input  logic [SEC_W-1:0]   sector_bytes,
  input  logic [BLK_W-1:0]   block_count,
  output geom_t              geom,
  output logic [2:0]         idx_shift,
  output logic               cfg_bad
);
  logic [BLK_W-1:0] blocks_per_dev;
  logic [31:0]      sec32;
  logic [31:0]      bpd32;
  logic [31:0]      sec_units32;

  always_comb begin
    cfg_bad = (bank_lg == 2'd3) || (dev_lg == 2'd3) || (max_lg == 2'd3) ||
              (size_lg == 2'd3) || (dev_lg > max_lg) || (dev_lg > bank_lg) ||
              ((dev_lg != max_lg) && (dev_lg != 2'd0));
  end

  assign idx_shift = {1'b0, bank_lg} + {1'b0, max_lg} - {1'b0, dev_lg};

  // devices in bank = bank / device, so per-device count is a right shift
  assign blocks_per_dev = cfg_bad ? '0 : (block_count >> (bank_lg - dev_lg));
  assign sec32          = 32'(sector_bytes);
  assign bpd32          = 32'(blocks_per_dev);
  assign sec_units32    = sec32 >> 8;

  always_comb begin
    geom.dev_size_lg  = trailing_zeros(sec32) + trailing_zeros(bpd32);
    geom.wbuf_lg      = (bank_lg == 2'd0) ? 8'd8 : 8'd11;
    geom.blocks_m1    = 16'(bpd32 - 32'd1);
    geom.sector_units = sec_units32[15:0];
  end
endmodule

// File: rtl/fqr_table.sv
module fqr_table
  import fqr_pkg::*;
(
  input  logic [IDX_W-1:0] index,
  input  geom_t            geom,
  output logic [7:0]       entry
);
  always_comb begin
    case (index)
      7'h10: entry = 8'h51;
      7'h11: entry = 8'h52;
      7'h12: entry = 8'h59;
      7'h13: entry = 8'h01;
      7'h15: entry = 8'h31;
      7'h1B: entry = 8'h45;
      7'h1C: entry = 8'h55;
      7'h1F: entry = 8'h07;
      7'h20: entry = 8'h07;
      7'h21: entry = 8'h0A;
      7'h23: entry = 8'h04;
      7'h24: entry = 8'h04;
      7'h25: entry = 8'h04;
      7'h27: entry = geom.dev_size_lg;
      7'h28: entry = 8'h02;
      7'h2A: entry = geom.wbuf_lg;
      7'h2C: entry = 8'h01;
      7'h2D: entry = geom.blocks_m1[7:0];
      7'h2E: entry = geom.blocks_m1[15:8];
      7'h2F: entry = geom.sector_units[7:0];
      7'h30: entry = geom.sector_units[15:8];
      7'h31: entry = 8'h50;
      7'h32: entry = 8'h52;
      7'h33: entry = 8'h49;
      7'h34: entry = 8'h31;
      7'h35: entry = 8'h30;
      7'h3F: entry = 8'h01;
      default: entry = 8'h00;
    endcase
  end
endmodule

// File: rtl/fqr_slice.sv
module fqr_slice
  import fqr_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] slice_offset,
  input  logic              id_mode,
  input  wcode_t            bank_lg,
  input  wcode_t            dev_lg,
  input  wcode_t            max_lg,
  input  logic [2:0]        idx_shift,
  input  logic [15:0]       mfr_code,
  input  logic [15:0]       dev_code,
  input  geom_t             geom,
  output logic [WORD_W-1:0] lanes
);
  logic [ADDR_W-1:0] scaled;
  logic [7:0]        tbl_byte;
  logic [7:0]        entry;
  logic              in_range;
  logic [WORD_W-1:0] dev_word;
  logic [1:0]        dmask;
  logic [2:0]        bank_bytes;

  assign scaled     = slice_offset >> idx_shift;
  assign in_range   = scaled < ADDR_W'(TABLE_LEN);
  assign dmask      = lane_mask(dev_lg);
  assign bank_bytes = 3'd1 << bank_lg;

  fqr_table u_table (
    .index (scaled[IDX_W-1:0]),
    .geom  (geom),
    .entry (tbl_byte)
  );

  assign entry = in_range ? tbl_byte : 8'h00;

  // response of one device, before copying across the bank
  always_comb begin
    dev_word = '0;
    if (id_mode) begin
      if (scaled[7:0] == 8'd0)      dev_word = {16'h0, mfr_code};
      else if (scaled[7:0] == 8'd1) dev_word = {16'h0, dev_code};
      dev_word = dev_word & width_mask(dev_lg);
    end else if (dev_lg != max_lg) begin
      dev_word = {WORD_BYTES{entry}} & width_mask(max_lg);
    end else begin
      dev_word = {24'h0, entry};
    end
  end

  for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
    always_comb begin
      lanes[8*l +: 8] = 8'h00;
      if (3'(l) < bank_bytes)
        lanes[8*l +: 8] = dev_word[8*(2'(l) & dmask) +: 8];
    end
  end
endmodule

// File: rtl/flash_query_responder.sv
module flash_query_responder
  import fqr_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SEC_W  = 24,
  parameter int BLK_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic              req_id_mode,
  input  logic [1:0]        req_size_lg,
  input  logic [1:0]        cfg_bank_lg,
  input  logic [1:0]        cfg_dev_lg,
  input  logic [1:0]        cfg_max_lg,
  input  logic [15:0]       cfg_mfr_code,
  input  logic [15:0]       cfg_dev_code,
  input  logic [SEC_W-1:0]  cfg_sector_bytes,
  input  logic [BLK_W-1:0]  cfg_block_count,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_data,
  output logic              rsp_cfg_error
);
  localparam int SLICES = WORD_BYTES;

  geom_t             geom;
  logic [2:0]        idx_shift;
  logic              cfg_bad;
  logic [WORD_W-1:0] slice_data [SLICES];
  logic [WORD_W-1:0] assembled;
  logic [1:0]        nsl_lg;
  logic [2:0]        slice_count;
  logic [1:0]        bmask;

  fqr_geometry #(.SEC_W(SEC_W), .BLK_W(BLK_W)) u_geom (
    .bank_lg      (cfg_bank_lg),
    .dev_lg       (cfg_dev_lg),
    .max_lg       (cfg_max_lg),
    .size_lg      (req_size_lg),
    .sector_bytes (cfg_sector_bytes),
    .block_count  (cfg_block_count),
    .geom         (geom),
    .idx_shift    (idx_shift),
    .cfg_bad      (cfg_bad)
  );

  for (genvar k = 0; k < SLICES; k++) begin : g_slice
    logic [ADDR_W-1:0] off_k;
    assign off_k = req_offset + (ADDR_W'(k) << cfg_bank_lg);
    fqr_slice #(.ADDR_W(ADDR_W)) u_slice (
      .slice_offset (off_k),
      .id_mode      (req_id_mode),
      .bank_lg      (cfg_bank_lg),
      .dev_lg       (cfg_dev_lg),
      .max_lg       (cfg_max_lg),
      .idx_shift    (idx_shift),
      .mfr_code     (cfg_mfr_code),
      .dev_code     (cfg_dev_code),
      .geom         (geom),
      .lanes        (slice_data[k])
    );
  end

  assign nsl_lg      = (req_size_lg > cfg_bank_lg) ? (req_size_lg - cfg_bank_lg) : 2'd0;
  assign slice_count = 3'd1 << nsl_lg;
  assign bmask       = lane_mask(cfg_bank_lg);

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byte
    logic [1:0] k_sel;
    logic [1:0] lane;
    assign k_sel = 2'(b) >> cfg_bank_lg;
    assign lane  = 2'(b) & bmask;
    always_comb begin
      assembled[8*b +: 8] = 8'h00;
      if ({1'b0, k_sel} < slice_count)
        assembled[8*b +: 8] = slice_data[k_sel][8*lane +: 8];
    end
  end

  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_data      <= '0;
      rsp_cfg_error <= 1'b0;
    end else if (req_ready) begin
      rsp_valid     <= req_valid;
      rsp_data      <= (req_valid && !cfg_bad) ? assembled : '0;
      rsp_cfg_error <= req_valid && cfg_bad;
    end
  end
endmodule

// File: rtl/fqr_checker.sv
module fqr_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_data,
  input logic        rsp_cfg_error
);
  AST_ACCEPT_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R1
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_cfg_error)); // R1
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid && !req_valid |=> !rsp_valid); // R1
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_cfg_error |-> rsp_valid && rsp_data == 32'h0); // R11
endmodule

bind flash_query_responder fqr_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .rsp_cfg_error (rsp_cfg_error)
);

// File: tb/flash_query_responder_tb.sv
module flash_query_responder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_offset = '0;
  logic        req_id_mode = 1'b0;
  logic [1:0]  req_size_lg = '0;
  logic [1:0]  cfg_bank_lg = '0, cfg_dev_lg = '0, cfg_max_lg = '0;
  logic [15:0] cfg_mfr_code = 16'h0089, cfg_dev_code = 16'h8918;
  logic [23:0] cfg_sector_bytes = 24'h020000;
  logic [15:0] cfg_block_count = 16'd64;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rsp_cfg_error;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];
  string       cur_tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_query_responder u_dut (.*);

  function automatic int tbl(int idx, int bw, int dw, int sec, int blk);
    longint sz;
    int n, bpd;
    bpd = blk / (bw / dw);
    sz = longint'(sec) * bpd;
    n = 0;
    while (n < 63 && ((sz >> n) & 1) == 0) n++;
    case (idx)
      'h10: return 'h51; 'h11: return 'h52; 'h12: return 'h59; 'h13: return 1;
      'h15: return 'h31; 'h1B: return 'h45; 'h1C: return 'h55; 'h1F: return 7;
      'h20: return 7; 'h21: return 'h0A; 'h23, 'h24, 'h25: return 4;
      'h27: return n & 255; 'h28: return 2; 'h2A: return (bw == 1) ? 8 : 11;
      'h2C: return 1; 'h2D: return (bpd - 1) & 255; 'h2E: return ((bpd - 1) >> 8) & 255;
      'h2F: return (sec >> 8) & 255; 'h30: return (sec >> 16) & 255;
      'h31: return 'h50; 'h32: return 'h52; 'h33: return 'h49; 'h34: return 'h31;
      'h35: return 'h30; 'h3F: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [32:0] model(int off, bit idm, int sz, int bc, int dc, int mc);
    int bw, dw, mw, rw, ns, so, idx, c, t;
    int ob[4];
    int db[4];
    logic [31:0] w;
    if (bc > 2 || dc > 2 || mc > 2 || sz > 2 || dc > mc || dc > bc || (dc != mc && dc != 0))
      return {1'b1, 32'h0};
    bw = 1 << bc; dw = 1 << dc; mw = 1 << mc; rw = 1 << sz;
    ns = (rw > bw) ? rw / bw : 1;
    for (int i = 0; i < 4; i++) ob[i] = 0;
    for (int s = 0; s < ns; s++) begin
      so = off + s * bw;
      idx = so >> (bc + mc - dc);
      for (int j = 0; j < 4; j++) db[j] = 0;
      if (idm) begin
        c = (idx % 256 == 0) ? int'(cfg_mfr_code) : (idx % 256 == 1) ? int'(cfg_dev_code) : 0;
        for (int j = 0; j < dw && j < 2; j++) db[j] = (c >> (8 * j)) & 255;
      end else begin
        t = (idx >= 'h52) ? 0 : tbl(idx, bw, dw, int'(cfg_sector_bytes), int'(cfg_block_count));
        db[0] = t;
        if (dw < mw) for (int j = 1; j < dw; j++) db[j] = t;
      end
      for (int l = 0; l < bw; l++) ob[s * bw + l] = db[l % dw];
    end
    for (int i = 0; i < 4; i++) w[8*i +: 8] = 8'(ob[i]);
    return {1'b0, w};
  endfunction

  logic        prev_stall = 0;
  logic [32:0] prev_rsp;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_stall) begin
        checks++;
        if (!rsp_valid || {rsp_cfg_error, rsp_data} != prev_rsp) begin
          fails++;
          $display("FAIL R1 hold: got v=%0b %h exp v=1 %h", rsp_valid, {rsp_cfg_error, rsp_data}, prev_rsp);
        end
        checks++;
        if (req_ready !== rsp_ready) begin
          fails++;
          $display("FAIL R1 ready: got %0b exp %0b", req_ready, rsp_ready);
        end
      end
      if (rsp_valid && rsp_ready) begin
        logic [32:0] e;
        string tg;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R1 unexpected response: got %h exp none", rsp_data);
        end else begin
          e = exp_q.pop_front();
          tg = tag_q.pop_front();
          if ({rsp_cfg_error, rsp_data} !== e) begin
            fails++;
            $display("FAIL %s: got %h exp %h", tg, {rsp_cfg_error, rsp_data}, e);
          end
        end
      end
      if (req_valid && req_ready) begin
        exp_q.push_back(model(int'(req_offset), req_id_mode, int'(req_size_lg),
                              int'(cfg_bank_lg), int'(cfg_dev_lg), int'(cfg_max_lg)));
        tag_q.push_back(cur_tag);
      end
      prev_stall = rsp_valid && !rsp_ready;
      prev_rsp = {rsp_cfg_error, rsp_data};
    end
  end

  task automatic send(input int off, input bit idm, input int sz, input string tg);
    @(posedge clk); #1;
    cur_tag = tg;
    req_offset = 24'(off); req_id_mode = idm; req_size_lg = 2'(sz); req_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic setcfg(input int b, input int d, input int m);
    @(posedge clk); #1;
    cfg_bank_lg = 2'(b); cfg_dev_lg = 2'(d); cfg_max_lg = 2'(m);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || rsp_data !== 32'h0 || req_ready !== 1'b1) begin
      fails++;
      $display("FAIL R2 reset: got v=%0b d=%h r=%0b exp 0 0 1", rsp_valid, rsp_data, req_ready);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    // R4 R5 R6: full table sweep on a byte bank
    setcfg(0, 0, 0);
    for (int i = 0; i < 'h56; i++) send(i, 0, 0, (i >= 'h52) ? "R5" : (i == 'h27 || i == 'h2A || i >= 'h2D && i <= 'h30) ? "R6" : "R4");
    send('h1FF, 0, 0, "R5");
    send('h10, 0, 2, "R10");
    send('h2D, 0, 1, "R10");
    // R7 R3: byte mode on 16-bit parts in a 32-bit bank
    setcfg(2, 0, 1);
    send('h80, 0, 2, "R7");
    send('h88, 0, 2, "R3");
    send('h2A << 3, 0, 2, "R6");
    send('h27 << 3, 0, 2, "R6");
    send('h52 << 3, 0, 2, "R5");
    send('h80, 0, 0, "R7");
    // R8: 16-bit parts, 16 and 32-bit banks
    setcfg(1, 1, 1);
    send('h20, 0, 1, "R8");
    send('h20, 0, 2, "R10");
    send('h2F << 1, 0, 2, "R6");
    setcfg(2, 1, 1);
    send('h40, 0, 2, "R8");
    send('h44, 0, 2, "R3");
    // R9 identifier mode
    send(0, 1, 2, "R9");
    send(4, 1, 2, "R9");
    send(8, 1, 2, "R9");
    send('h400, 1, 2, "R9");
    setcfg(2, 0, 1);
    send(0, 1, 2, "R9");
    send(8, 1, 2, "R9");
    setcfg(0, 0, 0);
    send(0, 1, 2, "R10");
    // R11 errors
    setcfg(1, 2, 2); send('h20, 0, 2, "R11");
    setcfg(2, 2, 1); send('h20, 0, 2, "R11");
    setcfg(2, 1, 2); send('h20, 0, 2, "R11");
    setcfg(3, 0, 0); send('h20, 0, 2, "R11");
    setcfg(2, 1, 1); send('h20, 0, 3, "R11");
    // R1 back-pressure
    setcfg(2, 1, 1);
    @(posedge clk); #1 rsp_ready = 1'b0;
    fork
      begin repeat (6) @(posedge clk); #1 rsp_ready = 1'b1; end
    join_none
    send('h40, 0, 2, "R1");
    send('h44, 0, 2, "R1");
    send('h48, 0, 2, "R1");
    repeat (5) @(posedge clk);
    @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R1 pending: got %0d exp 0", exp_q.size());
    end
    finish_run();
  end
endmodule